// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces the conversions of a delta-sigma converter. It runs from a free-running input clock. A toggle flop splits that clock into an internal phase, so all sequencing decisions are made on every second input edge, called a tick. A convert request starts a conversion. The block counts the conversion period in ticks. Near the end it resolves the polarity mode, then loads the filter result into an output register and pulls an active-low data-ready flag low.

Timing differs by how a conversion starts:
- A conversion started from standby takes 1624 input clocks.
- While the request stays high, conversions repeat every 1622 input clocks.
- A fresh rising edge of the request during a conversion abandons that conversion and restarts.

The channel address is taken at each conversion start and reported with the result. The modulator, the filter and the serial read-out sit outside the block.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset `drdy_n` is 1, and `result` and `chan_out` are 0. The divider phase is zero, so the first tick is the second clock edge after reset is released. Ticks then fall on every other edge.
- R2: In standby, a conversion starts on the first tick edge at which `conv` is 1. `drdy_n` falls 1624 input clocks after that edge. Measured from the edge at which `conv` is first seen high, this is 1624 or 1625 clocks, depending on the phase.
- R3: If `conv` is 1 at the tick where a result is produced, the next conversion starts on that same edge. Its result appears 1622 clocks later.
- R4: `chan_in` is captured at the edge where each conversion starts. That value is output on `chan_out` together with the conversion's result.
- R5: `bipolar` is sampled 82 input clocks before `drdy_n` falls. A change after that point has no effect on the result.
- R6: When the sampled `bipolar` is 1, `result` = (`filt_in` + 2^(RES_W-1)) mod 2^RES_W. When it is 0, `result` = `filt_in`. `filt_in` is sampled on the edge where `drdy_n` falls.
- R7: A rising edge of `conv` abandons a conversion in progress. The rising edge means `conv` was 0 at one tick and is 1 at the next. The aborted conversion produces no result. A new conversion starts at that tick and gives its result 1622 clocks later.
- R8: If `conv` is 0 at the tick where a result is produced, the block returns to standby. It then holds `result`, `chan_out` and `drdy_n` with no further results.
- R9: `drdy_n` goes to 1 on the clock edge after `rd_done` is seen high. Without `rd_done`, it rises two input clocks before the next result is loaded.
- R10: With RES_W = 20 the bipolar offset is 80000h, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv | input | 1 | Convert request (level; a rising edge restarts) |
| chan_in | input | CH_W | Channel address for the next conversion |
| bipolar | input | 1 | Polarity select: 1 bipolar, 0 unipolar |
| filt_in | input | RES_W | Raw filter result |
| rd_done | input | 1 | Read-done strobe, releases data-ready |
| chan_out | output | CH_W | Channel of the latched result |
| result | output | RES_W | Latched, polarity-processed result |
| drdy_n | output | 1 | Active-low data-ready |

## Verification
The bench starts conversions from standby on both divider phases. A sequencer that ignored the half-rate phase would be off by one clock on one of them. It also checks that the first result comes after 1624 clocks and later results after 1622; swapped or equal counts would misplace every result.

The polarity input is toggled just outside and just inside the 82-clock window. Sampling too early or too late picks up the wrong offset. A near-full input checks that the bipolar offset wraps modulo the word width.

An abort mid-conversion checks that the old result is suppressed and the restart gets the run length. A standby return checks that no stray result appears and that data-ready holds until the read strobe.

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq #(
  parameter int RES_W         = 16,
  parameter int CH_W          = 2,
  parameter int RUN_TICKS     = 811,
  parameter int STBY_TICKS    = 812,
  parameter int POL_WIN_TICKS = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             bipolar,
  input  logic [RES_W-1:0] filt_in,
  input  logic             rd_done,
  output logic [CH_W-1:0]  chan_out,
  output logic [RES_W-1:0] result,
  output logic             drdy_n
);
  localparam int CNT_W = $clog2(STBY_TICKS);
  localparam logic [CNT_W-1:0] LOAD_RUN  = CNT_W'(RUN_TICKS - 1);
  localparam logic [CNT_W-1:0] LOAD_STBY = CNT_W'(STBY_TICKS - 1);
  localparam logic [CNT_W-1:0] WIN_AT    = CNT_W'(POL_WIN_TICKS);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [RES_W-1:0] OFFSET    = RES_W'(1) << (RES_W - 1);

  logic             ph, busy, conv_prev, pol_q;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chan_cur;

  wire tick      = ph;
  wire conv_rise = conv & ~conv_prev;
  wire last      = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      busy      <= 1'b0;
      conv_prev <= 1'b0;
      pol_q     <= 1'b0;
      cnt       <= '0;
      chan_cur  <= '0;
      chan_out  <= '0;
      result    <= '0;
      drdy_n    <= 1'b1;
    end else begin
      ph <= ~ph;
      if (rd_done) drdy_n <= 1'b1;
      if (tick) begin
        conv_prev <= conv;
        if (!busy) begin
          if (conv) begin
            busy     <= 1'b1;
            cnt      <= LOAD_STBY;
            chan_cur <= chan_in;
            pol_q    <= bipolar;
          end
        end else if (last) begin
          result   <= pol_q ? filt_in + OFFSET : filt_in;
          chan_out <= chan_cur;
          drdy_n   <= 1'b0;
          if (conv) begin
            cnt      <= LOAD_RUN;
            chan_cur <= chan_in;
          end else begin
            busy <= 1'b0;
          end
        end else if (conv_rise) begin
          cnt      <= LOAD_RUN;
          chan_cur <= chan_in;
        end else begin
          cnt <= cnt - ONE;
          if (cnt == ONE)    drdy_n <= 1'b1;
          if (cnt == WIN_AT) pol_q  <= bipolar;
        end
      end
    end
  end

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> !ph); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_STBY); // R2

  AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$fell(drdy_n)); // R8

  AST_DATA_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(drdy_n)); // R6

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !(tick && last)) |=> drdy_n); // R9
endmodule

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic [1:0] chan_in = 2'd0;
  logic bipolar = 1'b0;
  logic rd_done = 1'b0;
  logic [15:0] filt16 = '0;
  logic [19:0] filt20 = '0;
  logic [1:0]  ch0, ch1;
  logic [15:0] res0;
  logic [19:0] res1;
  logic        dr0, dr1;

  int checks = 0, fails = 0;
  int edges = 0, last_fall = -1, nfall = 0, nfall_seen = 0;
  logic prevd = 1'b1;

  always #2 clk = ~clk;

  adc_conv_seq #(.RES_W(16)) u0 (.clk(clk), .rst_n(rst_n), .conv(conv), .chan_in(chan_in),
    .bipolar(bipolar), .filt_in(filt16), .rd_done(rd_done), .chan_out(ch0), .result(res0), .drdy_n(dr0));
  adc_conv_seq #(.RES_W(20)) u1 (.clk(clk), .rst_n(rst_n), .conv(conv), .chan_in(chan_in),
    .bipolar(bipolar), .filt_in(filt20), .rd_done(rd_done), .chan_out(ch1), .result(res1), .drdy_n(dr1));

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (prevd && !dr0) begin
        last_fall = edges;
        nfall++;
      end
      edges++;
    end
    prevd = dr0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (edges != n) @(negedge clk);
  endtask

  task automatic check_conv(input int f, input int ch, input int e16, input int e20, input string req);
    wait_to(f + 1);
    chk(nfall == nfall_seen + 1, {req, " one result"}, nfall - nfall_seen, 1);
    chk(last_fall == f, {req, " fall edge"}, last_fall, f);
    chk(dr1 == 1'b0, {req, " drdy 20b"}, dr1, 0);
    chk(ch0 == ch, "R4 channel", ch0, ch);
    chk(res0 == e16, {req, " R6 result 16b"}, res0, e16);
    chk(res1 == e20, {req, " R10 result 20b"}, res1, e20);
    nfall_seen = nfall;
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", edges);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0, f1, f2, f3, f4, f5, d, r, fb;
    repeat (3) @(negedge clk);
    chk(dr0 == 1'b1 && dr1 == 1'b1, "R1 reset drdy", dr0, 1);
    chk(res0 == 0 && res1 == 0, "R1 reset result", res0, 0);
    chk(ch0 == 0, "R1 reset chan", ch0, 0);
    rst_n = 1'b1;

    wait_to(10);
    e0 = edges;
    conv = 1'b1; chan_in = 2'd2; bipolar = 1'b0; filt16 = 16'h1234; filt20 = 20'h12345;
    f1 = e0 + 1625;
    wait_to(e0 + 10);
    chan_in = 2'd1;
    check_conv(f1, 2, 16'h1234, 20'h12345, "R2 even phase");

    f2 = f1 + 1622;
    wait_to(f2 - 90); bipolar = 1'b1;
    wait_to(f2 - 40); bipolar = 1'b0; chan_in = 2'd3;
    wait_to(f2 - 2);
    chk(dr0 == 1'b0, "R9 held low", dr0, 0);
    wait_to(f2 - 1);
    chk(dr0 == 1'b1, "R9 early release", dr0, 1);
    check_conv(f2, 1, 16'h9234, 20'h92345, "R3 R5 run");

    wait_to(f2 + 5); bipolar = 1'b1; filt16 = 16'hFFFF; filt20 = 20'hFFFFF;
    f3 = f2 + 1622;
    check_conv(f3, 3, 16'h7FFF, 20'h7FFFF, "R6 wrap");

    wait_to(f3 + 5); rd_done = 1'b1;
    wait_to(f3 + 6); rd_done = 1'b0;
    chk(dr0 == 1'b1 && dr1 == 1'b1, "R9 read release", dr0, 1);

    d = f3 + 400;
    wait_to(d); conv = 1'b0; chan_in = 2'd0; bipolar = 1'b0;
    wait_to(d + 4); conv = 1'b1;
    r = ((d + 4) % 2 == 1) ? d + 4 : d + 5;
    f4 = r + 1622;
    check_conv(f4, 0, 16'hFFFF, 20'hFFFFF, "R7 abort");

    wait_to(f4 + 5); conv = 1'b0; filt16 = 16'h0042; filt20 = 20'h00042; chan_in = 2'd1;
    f5 = f4 + 1622;
    check_conv(f5, 0, 16'h0042, 20'h00042, "R3 last");

    wait_to(f5 + 2000);
    chk(nfall == nfall_seen, "R8 no new result", nfall, nfall_seen);
    chk(dr0 == 1'b0, "R8 drdy held", dr0, 0);
    chk(res0 == 16'h0042, "R8 result held", res0, 16'h0042);
    rd_done = 1'b1;
    wait_to(f5 + 2001); rd_done = 1'b0;
    chk(dr0 == 1'b1, "R9 read in standby", dr0, 1);

    wait_to(((edges % 2) == 1) ? edges + 2 : edges + 1);
    e0 = edges;
    conv = 1'b1; bipolar = 1'b1; chan_in = 2'd3; filt16 = 16'h0001; filt20 = 20'h00001;
    fb = e0 + 1624;
    wait_to(e0 + 4); chan_in = 2'd2;
    check_conv(fb, 3, 16'h8001, 20'h80001, "R2 odd phase");
    wait_to(fb + 5); conv = 1'b0;
    check_conv(fb + 1622, 2, 16'h8001, 20'h80001, "R3 odd run");
    wait_to(fb + 1622 + 1700);
    chk(nfall == nfall_seen, "R8 standby again", nfall, nfall_seen);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule